// File: doc/BRIEF.md
# Dual-Clock FIFO With Selectable Flag Timing

This block is a FIFO of 36-bit words with separate write and read clocks. The two clocks may be unrelated, or they may be one and the same clock. Each pointer is kept in its own clock domain. The pointer is passed to the other domain as Gray code through a chain of synchronizer flops. Every flag is formed in the domain that uses it: full and almost-full in the write domain, empty and almost-empty in the read domain.

A master reset latches two settings. The first is the flag timing. In standard timing, the read-side flag means "empty", the write-side flag means "full", and a word reaches the output only after a read. In first-word-fall-through timing, the read-side flag means "output word valid", the write-side flag means "room available", and the oldest word is presented without a request. The second setting is a default threshold for the almost-empty and almost-full flags. Both thresholds can later be replaced with programmed values, either in one write-clock cycle from the data bus or bit by bit on a serial input. A partial reset empties the FIFO but keeps the timing mode and both thresholds.

Top module: `dcf_flagsel_top`

## Requirements
- R1: The reset state holds while `mrst_n` is low, and the block latches `fwft_sel` and `ofs_sel` during that time. After release in standard timing, the outputs are `flag_e`=1, `flag_f`=0, `aempty`=1 and `afull`=0. After release in fall-through timing (`fwft_sel`=1), they are `flag_e`=0 and `flag_f`=1.
- R2: In standard timing, the words come out in the order written. `rdata` changes only on a read clock edge where `ren`=1 and `flag_e`=0, and that edge shows the oldest stored word.
- R3: In fall-through timing, the oldest word appears on `rdata` with `flag_e`=1 and no read request. A read (`ren`=1 while `flag_e`=1) moves the next word onto `rdata`. Without a read, `rdata` is held.
- R4: A write is ignored when the FIFO is full. Full means `flag_f`=1 in standard timing and `flag_f`=0 in fall-through timing. An ignored write leaves the stored words unchanged.
- R5: A read in standard timing while `flag_e`=1 is ignored. `rdata` is held, and the next word written is also the next word read.
- R6: A write and a read on the same clock edge are both carried out. No word is lost and none is duplicated.
- R7: `aempty`=1 while the stored count is at or below the almost-empty threshold. In fall-through timing, the word shown on `rdata` counts as stored.
- R8: `afull`=1 while the free memory space is at or below the almost-full threshold. The memory holds 2^ADDR_W words.
- R9: At master reset, both thresholds take a default value set by `ofs_sel`: 00 gives 8, 01 gives 16, and 10 or 11 gives 64.
- R10: When `par_ld`=1 at a write clock edge, the almost-empty threshold is loaded from `wdata[ADDR_W-1:0]` and the almost-full threshold from `wdata[2*ADDR_W-1:ADDR_W]`. That cycle stores no data word.
- R11: At each write clock edge with `ser_en`=1 (and `par_ld`=0), one bit of `ser_din` is shifted in. A run of 2*ADDR_W bits loads the almost-empty threshold first, most significant bit first, and then the almost-full threshold, also most significant bit first.
- R12: While `prst_n` is low, all stored words are cleared. The timing mode and both thresholds are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low; clears data and latches the configuration |
| prst_n | input | 1 | Partial reset, active low; clears data only |
| fwft_sel | input | 1 | Timing select latched at master reset (1 = fall-through) |
| ofs_sel | input | 2 | Default threshold select latched at master reset |
| wen | input | 1 | Write request |
| wdata | input | 36 | Write data and parallel threshold value |
| par_ld | input | 1 | Parallel threshold load |
| ser_en | input | 1 | Serial threshold shift enable |
| ser_din | input | 1 | Serial threshold data bit |
| ren | input | 1 | Read request |
| rdata | output | 36 | Read data |
| flag_e | output | 1 | Empty (standard) or output valid (fall-through) |
| flag_f | output | 1 | Full (standard) or room available (fall-through) |
| aempty | output | 1 | Almost-empty flag |
| afull | output | 1 | Almost-full flag |

## Verification
In standard timing, a read returns its word after the read edge itself, and full and almost-full respond to a write on that same edge. A write is seen by the read side only after two synchronizer edges. So empty and almost-empty move two read edges after the write, and the fall-through output loads one edge after that. Reads reach the write-side flags with the same two-edge delay. The bench drives each input on the falling edge and reads outputs on a later falling edge. Before it checks any flag that crosses domains, it waits four or five cycles, which covers every delay above.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   typedef enum logic [1:0] {
      OFS_8  = 2'b00,
      OFS_16 = 2'b01,
      OFS_64 = 2'b10
   } ofs_code_e;

   function automatic int dflt_ofs(input logic [1:0] code);
      case (code)
         OFS_8:   return 8;
         OFS_16:  return 16;
         default: return 64;
      endcase
   endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         clr,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dcf_sync needs at least two stages");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (clr) chain[0] <= '0;
            else     chain[0] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (clr) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/dcf_cfg.sv
module dcf_cfg #(
   parameter int OFS_W = 7
) (
   input  logic               clk,
   input  logic               mrst_n,
   input  logic [1:0]         ofs_sel,
   input  logic               par_ld,
   input  logic [2*OFS_W-1:0] par_val,
   input  logic               ser_en,
   input  logic               ser_din,
   output logic [OFS_W-1:0]   ae_ofs,
   output logic [OFS_W-1:0]   af_ofs
);
   import dcf_pkg::*;

   logic [OFS_W-1:0] dflt;
   logic [2*OFS_W-1:0] shreg;

   assign dflt  = OFS_W'(dflt_ofs(ofs_sel));
   assign shreg = {ae_ofs, af_ofs};

   always_ff @(posedge clk) begin
      if (!mrst_n) begin
         ae_ofs <= dflt;
         af_ofs <= dflt;
      end else if (par_ld) begin
         ae_ofs <= par_val[OFS_W-1:0];
         af_ofs <= par_val[2*OFS_W-1:OFS_W];
      end else if (ser_en) begin
         {ae_ofs, af_ofs} <= {shreg[2*OFS_W-2:0], ser_din};
      end
   end

   // R10: a parallel load takes effect on the next cycle
   p_par_load_r10: assert property (@(posedge clk) disable iff (!mrst_n)
      par_ld |=> (ae_ofs == $past(par_val[OFS_W-1:0])));
endmodule

// File: rtl/dcf_wside.sv
module dcf_wside #(
   parameter int ADDR_W = 7,
   localparam int PTR_W = ADDR_W + 1,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              fwft_sel,
   input  logic              wen,
   input  logic              par_ld,
   input  logic [PTR_W-1:0]  rgray_s,
   input  logic [ADDR_W-1:0] af_ofs,
   output logic              wr_ok,
   output logic [ADDR_W-1:0] waddr,
   output logic [PTR_W-1:0]  wgray,
   output logic              flag_f,
   output logic              afull
);
   logic             clr, fwft_q, full;
   logic [PTR_W-1:0] wbin, wbin_nx, rbin_s, wcount, free;

   function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
      logic [PTR_W-1:0] b;
      b[PTR_W-1] = g[PTR_W-1];
      for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   assign clr     = !mrst_n || !prst_n;
   assign rbin_s  = g2b(rgray_s);
   assign wcount  = wbin - rbin_s;
   assign free    = PTR_W'(DEPTH) - wcount;
   assign full    = (wcount == PTR_W'(DEPTH));
   assign wr_ok   = wen && !par_ld && !full;
   assign wbin_nx = wbin + PTR_W'(1);
   assign waddr   = wbin[ADDR_W-1:0];
   assign flag_f  = fwft_q ? !full : full;
   assign afull   = (free <= {1'b0, af_ofs});

   always_ff @(posedge clk) begin
      if (!mrst_n) fwft_q <= fwft_sel;
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (wr_ok) begin
         wbin  <= wbin_nx;
         wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
   end

   // R4: a write while full leaves the pointer alone
   p_full_write_r4: assert property (@(posedge clk) disable iff (clr)
      (full && wen) |=> $stable(wbin));
   // R4: never more than DEPTH words stored
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (clr)
      wcount <= PTR_W'(DEPTH));
   // R6: the crossing pointer changes by at most one bit per edge
   p_gray_step_r6: assert property (@(posedge clk) disable iff (clr)
      $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcf_rside.sv
module dcf_rside #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 36,
   localparam int PTR_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              fwft_sel,
   input  logic              ren,
   input  logic [PTR_W-1:0]  wgray_s,
   input  logic [ADDR_W-1:0] ae_ofs,
   input  logic [DATA_W-1:0] rd_word,
   output logic [ADDR_W-1:0] raddr,
   output logic [PTR_W-1:0]  rgray,
   output logic [DATA_W-1:0] rdata,
   output logic              flag_e,
   output logic              aempty
);
   logic             clr, fwft_q, ovalid, mem_empty, fetch;
   logic [PTR_W-1:0] rbin, rbin_nx, wbin_s, rcount, occ;

   function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
      logic [PTR_W-1:0] b;
      b[PTR_W-1] = g[PTR_W-1];
      for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   assign clr       = !mrst_n || !prst_n;
   assign wbin_s    = g2b(wgray_s);
   assign rcount    = wbin_s - rbin;
   assign mem_empty = (rcount == '0);
   assign rbin_nx   = rbin + PTR_W'(1);
   assign raddr     = rbin[ADDR_W-1:0];
   assign fetch     = fwft_q ? ((!ovalid || ren) && !mem_empty)
                             : (ren && !mem_empty);
   assign occ       = rcount + PTR_W'(fwft_q && ovalid);
   assign aempty    = (occ <= {1'b0, ae_ofs});
   assign flag_e    = fwft_q ? ovalid : mem_empty;

   always_ff @(posedge clk) begin
      if (!mrst_n) fwft_q <= fwft_sel;
   end

   always_ff @(posedge clk) begin
      if (clr) begin
         rbin   <= '0;
         rgray  <= '0;
         rdata  <= '0;
         ovalid <= 1'b0;
      end else begin
         if (fetch) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            rdata <= rd_word;
         end
         if (fwft_q) begin
            if (fetch)    ovalid <= 1'b1;
            else if (ren) ovalid <= 1'b0;
         end
      end
   end

   // R5: a standard-timing read while empty changes nothing
   p_empty_read_r5: assert property (@(posedge clk) disable iff (clr)
      (!fwft_q && mem_empty && ren) |=> ($stable(rbin) && $stable(rdata)));
   // R3: a presented word is held until it is read
   p_fwft_hold_r3: assert property (@(posedge clk) disable iff (clr)
      (fwft_q && ovalid && !ren) |=> (ovalid && $stable(rdata)));
   // R6: the crossing pointer changes by at most one bit per edge
   p_rgray_step_r6: assert property (@(posedge clk) disable iff (clr)
      $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcf_flagsel_top.sv
module dcf_flagsel_top #(
   parameter int DATA_W = 36,
   parameter int ADDR_W = 7,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              mrst_n,
   input  logic              prst_n,
   input  logic              fwft_sel,
   input  logic [1:0]        ofs_sel,
   input  logic              wen,
   input  logic [DATA_W-1:0] wdata,
   input  logic              par_ld,
   input  logic              ser_en,
   input  logic              ser_din,
   input  logic              ren,
   output logic [DATA_W-1:0] rdata,
   output logic              flag_e,
   output logic              flag_f,
   output logic              aempty,
   output logic              afull
);
   localparam int PTR_W = ADDR_W + 1;
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 7) begin : g_bad_depth
      $error("depth must exceed the largest default threshold");
   end
   if (DATA_W < 2 * ADDR_W) begin : g_bad_width
      $error("data bus too narrow for a parallel threshold load");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic              wr_ok, wclr, rclr;
   logic [ADDR_W-1:0] waddr, raddr, ae_ofs, af_ofs;
   logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;

   assign wclr = !mrst_n || !prst_n;
   assign rclr = wclr;

   dcf_cfg #(.OFS_W(ADDR_W)) u_cfg (
      .clk(wclk), .mrst_n(mrst_n), .ofs_sel(ofs_sel), .par_ld(par_ld),
      .par_val(wdata[2*ADDR_W-1:0]), .ser_en(ser_en), .ser_din(ser_din),
      .ae_ofs(ae_ofs), .af_ofs(af_ofs));

   dcf_wside #(.ADDR_W(ADDR_W)) u_wside (
      .clk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
      .wen(wen), .par_ld(par_ld), .rgray_s(rgray_s), .af_ofs(af_ofs),
      .wr_ok(wr_ok), .waddr(waddr), .wgray(wgray), .flag_f(flag_f),
      .afull(afull));

   dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rclk), .clr(rclr), .din(wgray), .dout(wgray_s));

   dcf_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wclk), .clr(wclr), .din(rgray), .dout(rgray_s));

   dcf_rside #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rside (
      .clk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
      .ren(ren), .wgray_s(wgray_s), .ae_ofs(ae_ofs), .rd_word(mem[raddr]),
      .raddr(raddr), .rgray(rgray), .rdata(rdata), .flag_e(flag_e),
      .aempty(aempty));

   always_ff @(posedge wclk) begin
      if (wr_ok) mem[waddr] <= wdata;
   end
endmodule

// File: tb/dcf_flagsel_top_test.sv
`timescale 1ns/1ps
module dcf_flagsel_top_test;
   localparam int DW = 36;
   localparam int AW = 7;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0;
   logic [1:0] ofs_sel = 2'b00;
   logic wen = 1'b0, par_ld = 1'b0, ser_en = 1'b0, ser_din = 1'b0, ren = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic flag_e, flag_f, aempty, afull;
   int checks = 0, bad = 0;

   always #10 clk = ~clk;

   dcf_flagsel_top uut (
      .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
      .fwft_sel(fwft_sel), .ofs_sel(ofs_sel), .wen(wen), .wdata(wdata),
      .par_ld(par_ld), .ser_en(ser_en), .ser_din(ser_din), .ren(ren),
      .rdata(rdata), .flag_e(flag_e), .flag_f(flag_f), .aempty(aempty),
      .afull(afull));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic master_reset(input logic fw, input logic [1:0] sel);
      @(negedge clk);
      mrst_n = 1'b0; fwft_sel = fw; ofs_sel = sel;
      idle(3);
      mrst_n = 1'b1;
      idle(1);
   endtask

   task automatic part_reset();
      @(negedge clk);
      prst_n = 1'b0;
      idle(3);
      prst_n = 1'b1;
      idle(1);
   endtask

   task automatic put(input logic [DW-1:0] d);
      wen = 1'b1; wdata = d;
      @(negedge clk);
      wen = 1'b0;
   endtask

   task automatic put_n(input int base, input int n);
      for (int i = 0; i < n; i++) put(DW'(base + i));
   endtask

   task automatic pull();
      ren = 1'b1;
      @(negedge clk);
      ren = 1'b0;
   endtask

   // R1, R2, R4, R5, R7, R8, R9 with threshold 8
   task automatic t_std_fill();
      int errs;
      master_reset(1'b0, 2'b00);
      check("R1 empty", flag_e, 1);
      check("R1 full", flag_f, 0);
      check("R1 aempty", aempty, 1);
      check("R1 afull", afull, 0);
      put_n(100, 8); idle(4);
      check("R7 aempty at 8", aempty, 1);
      check("R2 no data before read", rdata, 0);
      put_n(108, 1); idle(4);
      check("R7 aempty at 9", aempty, 0);
      put_n(109, 110); idle(4);
      check("R8 afull at 119", afull, 0);
      put_n(219, 1); idle(4);
      check("R8 afull at 120", afull, 1);
      put_n(220, 8);
      check("R4 full flag", flag_f, 1);
      put(36'hBAD);
      idle(4);
      errs = 0;
      for (int i = 0; i < DEPTH; i++) begin
         pull();
         if (rdata !== DW'(100 + i)) errs++;
      end
      check("R2 order of 128 reads", errs, 0);
      check("R4 last word", rdata, 227);
      check("R4 extra write dropped", flag_e, 1);
      pull();
      check("R5 read while empty holds", rdata, 227);
      put(36'h55); idle(4);
      pull();
      check("R5 pointer unchanged", rdata, 36'h55);
   endtask

   // R6: four words queued, then writes and reads on the same edges
   task automatic t_simul();
      int errs = 0;
      master_reset(1'b0, 2'b00);
      put_n(36'h300, 4); idle(4);
      for (int i = 0; i < 4; i++) begin
         wen = 1'b1; ren = 1'b1; wdata = DW'(36'h400 + i);
         @(negedge clk);
         if (rdata !== DW'(36'h300 + i)) errs++;
      end
      wen = 1'b0; ren = 1'b0;
      idle(4);
      for (int i = 0; i < 4; i++) begin
         pull();
         if (rdata !== DW'(36'h400 + i)) errs++;
      end
      check("R6 simultaneous order", errs, 0);
      check("R6 drained", flag_e, 1);
   endtask

   // R1, R3, R9 threshold 16, R10, R12
   task automatic t_fwft();
      master_reset(1'b1, 2'b01);
      check("R1 fwft ready low", flag_e, 0);
      check("R1 fwft room", flag_f, 1);
      put(36'hC00); idle(5);
      check("R3 word falls through", rdata, 36'hC00);
      check("R3 output valid", flag_e, 1);
      put_n(36'hC01, 15); idle(5);
      check("R9 aempty at 16", aempty, 1);
      check("R3 held without read", rdata, 36'hC00);
      put_n(36'hC10, 1); idle(5);
      check("R9 aempty at 17", aempty, 0);
      pull();
      check("R3 read advances", rdata, 36'hC01);
      part_reset();
      check("R12 cleared", flag_e, 0);
      check("R12 mode kept", flag_f, 1);
      put_n(36'hD00, 16); idle(5);
      check("R12 threshold kept", aempty, 1);
      part_reset();
      @(negedge clk);
      par_ld = 1'b1; wdata = DW'((3 << AW) | 5);
      @(negedge clk);
      par_ld = 1'b0; wdata = '0;
      idle(5);
      check("R10 no data stored", flag_e, 0);
      put_n(36'hE00, 5); idle(5);
      check("R10 aempty at 5", aempty, 1);
      put_n(36'hE05, 1); idle(5);
      check("R10 aempty at 6", aempty, 0);
      put_n(36'hE06, 119); idle(5);
      check("R10 afull free 4", afull, 0);
      put_n(36'hE80, 1); idle(5);
      check("R10 afull free 3", afull, 1);
   endtask

   // R11 serial load, R12 in standard timing
   task automatic t_serial();
      logic [2*AW-1:0] pat;
      master_reset(1'b0, 2'b00);
      pat = {AW'(3), AW'(2)};
      for (int i = 2 * AW - 1; i >= 0; i--) begin
         ser_en = 1'b1; ser_din = pat[i];
         @(negedge clk);
      end
      ser_en = 1'b0; ser_din = 1'b0;
      part_reset();
      check("R12 std mode kept", flag_e, 1);
      put_n(36'hF00, 3); idle(4);
      check("R11 aempty at 3", aempty, 1);
      put_n(36'hF03, 1); idle(4);
      check("R11 aempty at 4", aempty, 0);
      put_n(36'hF04, 121); idle(4);
      check("R11 afull free 3", afull, 0);
      put_n(36'hF7D, 1); idle(4);
      check("R11 afull free 2", afull, 1);
   endtask

   // R9 threshold 64
   task automatic t_dflt64();
      master_reset(1'b0, 2'b10);
      put_n(0, 63); idle(4);
      check("R9 aempty at 63", aempty, 1);
      check("R9 afull at 63", afull, 0);
      put_n(63, 1); idle(4);
      check("R9 aempty at 64", aempty, 1);
      check("R9 afull at 64", afull, 1);
      put_n(64, 1); idle(4);
      check("R9 aempty at 65", aempty, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      t_std_fill();
      t_simul();
      t_fwft();
      t_serial();
      t_dflt64();
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule